// File: doc/BRIEF.md
# Flash Read-Timing Calibration Engine

This block is the calibration and checksum part of a serial-flash controller. Software first programs a flash start address, a byte length, the chip-select 0 control word and the read-timing word. It then writes a start command to the control register. If the calibrate flag is set in that command, the engine first decodes a 4-bit clock-divisor code and a 4-bit read delay from the command. It rewrites the clock-frequency field of the chip-select 0 control word. For the fast divisors only, it also rewrites the matching delay nibble of the read-timing word.

After that step the engine fetches 32-bit words over a request/response port and adds each word to a wrapping checksum, until the length is used up. A one-cycle done pulse and a sticky status bit report completion. Software repeats the run with different delay settings and compares the checksums to find a working read timing.

The word-read port has two channels. On the request channel, `rd_req_valid` stays high with a stable `rd_req_addr` until `rd_req_ready` is seen. The memory side can therefore stall for as long as it likes. On the response channel, the engine raises `rd_rsp_ready` only while it waits for the one word it has asked for, so at most one read is outstanding. A response counts when `rd_rsp_valid` and `rd_rsp_ready` are both high at a clock edge. The register port is a plain synchronous write with a combinational read.

Top module: `flash_cal_engine`

## Requirements
- R1: After reset every register reads zero, `done` is low and `rd_req_valid` is low. The register word indexes are: 0 control, 1 flash address, 2 length, 3 checksum, 4 chip-select 0 control, 5 read timing, 6 status (bit0 busy, bit1 done flag).
- R2: Writing the control register with bit0 set while idle starts a run. The control register keeps the written value with bit0 cleared. The checksum and the done flag are cleared, and status bit0 reads 1 from the next cycle until the run ends.
- R3: When control bit1 (calibrate) is set, control bits [7:4] hold a divisor code. Codes 15, 7, 14, 6, 13, 5, 12, 4, 11, 3, 10, 2, 9, 1, 8, 0 select divisors 1 to 16 in that order. Bits [11:8] of the chip-select 0 control register become divisor minus one, and its other bits are kept.
- R4: When calibrating with a divisor of 1 to 5, control bits [11:8] (the delay) are written into read-timing bits [(divisor−1)×4+3 : (divisor−1)×4]. All other timing bits are kept.
- R5: When calibrating with a divisor of 6 to 16, the read-timing register is left unchanged.
- R6: When the calibrate flag is clear, neither the chip-select 0 control register nor the read-timing register changes.
- R7: A run reads ceil(length/4) words at the flash address, the address plus 4, and so on, in increasing order. A length of zero reads nothing and finishes at once.
- R8: The checksum register equals the sum, modulo 2^32, of all response words accepted in the run.
- R9: `rd_req_valid` held without `rd_req_ready` stays high with `rd_req_addr` unchanged on the next cycle. `rd_rsp_ready` is never high in the same cycle as `rd_req_valid`.
- R10: `done` is high for exactly one cycle per run. At the end of the run the flash address has advanced by 4 per word read, the length reads zero and status reads 2.
- R11: While busy, all register writes are ignored, including a new start command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| rd_req_valid | output | 1 | Word read request valid |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_req_addr | output | 32 | Byte address of the requested word |
| rd_rsp_valid | input | 1 | Response word valid |
| rd_rsp_ready | output | 1 | Engine waits for a response word |
| rd_rsp_data | input | 32 | Response word |
| done | output | 1 | One-cycle pulse at the end of a run |

## Verification
The assertions assume that the memory side returns at most one response for each accepted request. They also assume that `rd_rsp_valid` is raised only while a request is outstanding. The bench responder holds a single pending address, drives `rd_rsp_valid` only after taking a request, and drops it on the cycle after the handshake. The assertions also assume that `reg_addr` is within the seven defined indexes. The bench writes and reads only those indexes. It varies request back-pressure and response latency in a fixed cycle pattern, so stalls fall on different words of each run.

// File: rtl/flash_cal_pkg.sv
package flash_cal_pkg;
  localparam int REG_AW = 3;
  localparam int CODE_W = 4;
  localparam int NIB_W  = 4;

  localparam logic [REG_AW-1:0] A_CTRL   = 3'd0;
  localparam logic [REG_AW-1:0] A_FADDR  = 3'd1;
  localparam logic [REG_AW-1:0] A_LEN    = 3'd2;
  localparam logic [REG_AW-1:0] A_CSUM   = 3'd3;
  localparam logic [REG_AW-1:0] A_CS0    = 3'd4;
  localparam logic [REG_AW-1:0] A_TIMING = 3'd5;
  localparam logic [REG_AW-1:0] A_STATUS = 3'd6;

  localparam int CTL_START    = 0;
  localparam int CTL_CAL      = 1;
  localparam int CTL_CODE_LSB = 4;
  localparam int CTL_DLY_LSB  = 8;
  localparam int CS0_CLK_LSB  = 8;
  localparam int TUNABLE_MAX  = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CAL,
    ST_ISSUE,
    ST_WAIT,
    ST_FIN
  } eng_state_t;
endpackage

// File: rtl/flash_cal_decode.sv
module flash_cal_decode
  import flash_cal_pkg::*;
#(
  parameter int CW = CODE_W
) (
  input  logic [CW-1:0] code,
  output logic [CW:0]   divisor,
  output logic          tunable
);
  localparam int NSLOT = 1 << CW;
  localparam int HALF  = NSLOT / 2;

  logic [NSLOT-1:0] hit;

  // Slot g holds divisor g+1; even slots run down from the top code,
  // odd slots run down from the middle code.
  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    localparam int SLOT_CODE = ((g % 2) == 0) ? (NSLOT - 1 - g / 2) : (HALF - 1 - g / 2);
    assign hit[g] = (code == SLOT_CODE[CW-1:0]);
  end

  always_comb begin
    divisor = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (hit[i]) divisor = divisor | (CW+1)'(i + 1);
    end
  end

  assign tunable = (divisor != '0) && (divisor <= (CW+1)'(TUNABLE_MAX));
endmodule

// File: rtl/flash_cal_fsm.sv
module flash_cal_fsm
  import flash_cal_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic cal_en,
  input  logic len_zero,
  input  logic req_ready,
  input  logic rsp_valid,
  output logic busy,
  output logic cal_apply,
  output logic req_valid,
  output logic rsp_ready,
  output logic beat,
  output logic fin
);
  eng_state_t state, state_nx;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:  if (start_req) state_nx = cal_en ? ST_CAL : ST_ISSUE;
      ST_CAL:   state_nx = ST_ISSUE;
      ST_ISSUE: begin
        if (len_zero)       state_nx = ST_FIN;
        else if (req_ready) state_nx = ST_WAIT;
      end
      ST_WAIT:  if (rsp_valid) state_nx = ST_ISSUE;
      ST_FIN:   state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  assign busy      = (state != ST_IDLE);
  assign cal_apply = (state == ST_CAL);
  assign req_valid = (state == ST_ISSUE) && !len_zero;
  assign rsp_ready = (state == ST_WAIT);
  assign beat      = rsp_ready && rsp_valid;
  assign fin       = (state == ST_FIN);

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !fin);

  // R9
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && rsp_ready));

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> req_valid);
endmodule

// File: rtl/flash_cal_regs.sv
module flash_cal_regs
  import flash_cal_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              busy,
  input  logic              start_req,
  input  logic              cal_apply,
  input  logic [CODE_W:0]   divisor,
  input  logic              tunable,
  input  logic              beat,
  input  logic [DW-1:0]     beat_data,
  input  logic              fin,
  output logic [CODE_W-1:0] cal_code,
  output logic [DW-1:0]     flash_addr,
  output logic              len_zero
);
  localparam int STEP  = DW / 8;
  localparam int LSB_W = $clog2(DW);

  logic [DW-1:0] ctrl_q, len_q, csum_q, cs0_q, timing_q;
  logic          done_flag;
  logic [NIB_W-1:0]  delay;
  logic [CODE_W-1:0] div_m1;
  logic [LSB_W-1:0]  nib_lsb;

  assign cal_code = ctrl_q[CTL_CODE_LSB +: CODE_W];
  assign delay    = ctrl_q[CTL_DLY_LSB +: NIB_W];
  assign div_m1   = CODE_W'(divisor - (CODE_W+1)'(1));
  assign nib_lsb  = LSB_W'(div_m1) * LSB_W'(NIB_W);
  assign len_zero = (len_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      flash_addr <= '0;
      len_q      <= '0;
      csum_q     <= '0;
      cs0_q      <= '0;
      timing_q   <= '0;
      done_flag  <= 1'b0;
    end else begin
      if (reg_we && !busy) begin
        unique case (reg_addr)
          A_CTRL:   ctrl_q     <= reg_wdata & ~(DW'(1) << CTL_START);
          A_FADDR:  flash_addr <= reg_wdata;
          A_LEN:    len_q      <= reg_wdata;
          A_CS0:    cs0_q      <= reg_wdata;
          A_TIMING: timing_q   <= reg_wdata;
          default:  ;
        endcase
      end
      if (start_req) begin
        csum_q    <= '0;
        done_flag <= 1'b0;
      end
      if (cal_apply) begin
        cs0_q[CS0_CLK_LSB +: CODE_W] <= div_m1;
        if (tunable) timing_q[nib_lsb +: NIB_W] <= delay;
      end
      if (beat) begin
        csum_q     <= csum_q + beat_data;
        flash_addr <= flash_addr + DW'(STEP);
        len_q      <= (len_q <= DW'(STEP)) ? '0 : len_q - DW'(STEP);
      end
      if (fin) done_flag <= 1'b1;
    end
  end

  always_comb begin
    unique case (reg_addr)
      A_CTRL:   reg_rdata = ctrl_q;
      A_FADDR:  reg_rdata = flash_addr;
      A_LEN:    reg_rdata = len_q;
      A_CSUM:   reg_rdata = csum_q;
      A_CS0:    reg_rdata = cs0_q;
      A_TIMING: reg_rdata = timing_q;
      A_STATUS: reg_rdata = {{(DW-2){1'b0}}, done_flag, busy};
      default:  reg_rdata = '0;
    endcase
  end

  // R5
  slow_div_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_apply && !tunable) |=> $stable(timing_q));

  // R11
  busy_len_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_we && reg_addr == A_LEN && !beat) |=> $stable(len_q));

  // R8
  csum_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!beat && !start_req) |=> $stable(csum_q));
endmodule

// File: rtl/flash_cal_engine.sv
module flash_cal_engine
  import flash_cal_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [DW-1:0]     rd_req_addr,
  input  logic              rd_rsp_valid,
  output logic              rd_rsp_ready,
  input  logic [DW-1:0]     rd_rsp_data,
  output logic              done
);
  logic              busy, start_req, cal_apply, beat, fin, len_zero, tunable;
  logic [CODE_W-1:0] cal_code;
  logic [CODE_W:0]   divisor;

  assign start_req = reg_we && (reg_addr == A_CTRL) && reg_wdata[CTL_START] && !busy;
  assign done      = fin;

  flash_cal_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (start_req),
    .cal_en    (reg_wdata[CTL_CAL]),
    .len_zero  (len_zero),
    .req_ready (rd_req_ready),
    .rsp_valid (rd_rsp_valid),
    .busy      (busy),
    .cal_apply (cal_apply),
    .req_valid (rd_req_valid),
    .rsp_ready (rd_rsp_ready),
    .beat      (beat),
    .fin       (fin)
  );

  flash_cal_decode #(.CW(CODE_W)) u_dec (
    .code    (cal_code),
    .divisor (divisor),
    .tunable (tunable)
  );

  flash_cal_regs #(.DW(DW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .busy       (busy),
    .start_req  (start_req),
    .cal_apply  (cal_apply),
    .divisor    (divisor),
    .tunable    (tunable),
    .beat       (beat),
    .beat_data  (rd_rsp_data),
    .fin        (fin),
    .cal_code   (cal_code),
    .flash_addr (rd_req_addr),
    .len_zero   (len_zero)
  );

  // R9
  req_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> $stable(rd_req_addr));

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !rd_req_valid && !rd_rsp_ready);
endmodule

// File: tb/flash_cal_engine_tb.sv
`timescale 1ns/1ps
module flash_cal_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        rd_req_valid, rd_rsp_ready, done;
  logic        rd_req_ready = 1'b0;
  logic        rd_rsp_valid = 1'b0;
  logic [31:0] rd_req_addr;
  logic [31:0] rd_rsp_data = '0;

  int total = 0, bad = 0;
  int done_cnt = 0, words_seen = 0, cyc = 0;
  logic [31:0] exp_next_addr = '0, model_sum = '0;
  bit pending = 0;
  int lat = 0;
  logic [31:0] pend_addr = '0;
  bit prev_valid = 0, prev_ready = 0, prev_done = 0;
  logic [31:0] prev_addr = '0;

  always #10 clk = ~clk;

  flash_cal_engine u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_req_addr(rd_req_addr), .rd_rsp_valid(rd_rsp_valid),
    .rd_rsp_ready(rd_rsp_ready), .rd_rsp_data(rd_rsp_data), .done(done)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return a * 32'h9E3779B1 + 32'hF1234567;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Memory responder and per-clock reference comparisons
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (rst_n) begin
        if (prev_valid && !prev_ready) begin
          chk("R9 valid held", {31'b0, rd_req_valid}, 32'd1);
          chk("R9 addr held", rd_req_addr, prev_addr);
        end
        if (rd_req_valid) chk("R9 no overlap", {31'b0, rd_rsp_ready}, 32'd0);
        if (done && prev_done) chk("R10 done width", 32'd2, 32'd1);
        if (done) done_cnt++;
        if (rd_req_valid && rd_req_ready) begin
          chk("R7 word address", rd_req_addr, exp_next_addr);
          exp_next_addr = exp_next_addr + 32'd4;
          words_seen++;
          pending = 1;
          pend_addr = rd_req_addr;
          lat = 1 + (words_seen % 3);
        end else if (rd_rsp_valid && rd_rsp_ready) begin
          model_sum = model_sum + mem_word(pend_addr);
          pending = 0;
        end
      end
      prev_valid = rd_req_valid;
      prev_ready = rd_req_ready;
      prev_addr  = rd_req_addr;
      prev_done  = done;
      @(posedge clk);
      #1;
      rd_req_ready = (cyc % 3) != 1;
      if (pending && lat > 0) lat--;
      rd_rsp_valid = pending && (lat == 0);
      rd_rsp_data  = pending ? mem_word(pend_addr) : 32'hDEADBEEF;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic run_case(input bit cal, input int code, input int dly,
                          input logic [31:0] fa, input logic [31:0] ln,
                          input logic [31:0] t0, input logic [31:0] c0,
                          input bit poke);
    int tbl[16] = '{15, 7, 14, 6, 13, 5, 12, 4, 11, 3, 10, 2, 9, 1, 8, 0};
    int div = 0, nwords, d0;
    logic [31:0] ctl, v, exp_t, exp_c, exp_sum;
    for (int i = 0; i < 16; i++) if (tbl[i] == code) div = i + 1;
    nwords = int'((ln + 32'd3) / 32'd4);
    exp_sum = '0;
    for (int k = 0; k < nwords; k++) exp_sum = exp_sum + mem_word(fa + 32'(4 * k));
    exp_t = t0; exp_c = c0;
    if (cal) begin
      exp_c[11:8] = 4'(div - 1);
      if (div <= 5) exp_t[(div-1)*4 +: 4] = 4'(dly);
    end
    ctl = (32'(dly) << 8) | (32'(code) << 4) | (32'(cal) << 1) | 32'd1;
    wr(3'd5, t0); wr(3'd4, c0); wr(3'd1, fa); wr(3'd2, ln);
    exp_next_addr = fa; words_seen = 0; model_sum = '0;
    d0 = done_cnt;
    wr(3'd0, ctl);
    rd(3'd6, v);
    chk("R2 busy after start", v & 32'd1, 32'd1);
    if (poke) begin
      wr(3'd2, 32'd100);
      wr(3'd0, 32'h0000_0F73);
      wr(3'd5, 32'h5555_5555);
    end
    for (int w = 0; w < 2000 && done_cnt == d0; w++) @(negedge clk);
    chk("R10 one done", 32'(done_cnt - d0), 32'd1);
    repeat (8) @(negedge clk);
    chk("R10 no extra done", 32'(done_cnt - d0), 32'd1);
    chk("R7 word count", 32'(words_seen), 32'(nwords));
    rd(3'd3, v); chk("R8 checksum", v, exp_sum);
    chk("R8 model sum", v, model_sum);
    rd(3'd1, v); chk("R10 final addr", v, fa + 32'(4 * nwords));
    rd(3'd2, v); chk("R10 len zero", v, 32'd0);
    rd(3'd6, v); chk("R10 status", v, 32'd2);
    rd(3'd4, v); chk(cal ? "R3 cs0 clock field" : "R6 cs0 kept", v, exp_c);
    rd(3'd5, v);
    chk(!cal ? "R6 timing kept" : (div <= 5 ? "R4 timing nibble" : "R5 timing kept"), v, exp_t);
    rd(3'd0, v); chk(poke ? "R11 ctrl kept" : "R2 ctrl stored", v, ctl & ~32'd1);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), v);
      chk("R1 reset reg", v, 32'd0);
    end
    chk("R1 done low", {31'b0, done}, 32'd0);
    chk("R1 req low", {31'b0, rd_req_valid}, 32'd0);
    // divisor 1, delay 0xA
    run_case(1, 15, 10, 32'h0000_1000, 32'd16, 32'hFFFF_FFFF, 32'h1234_5678, 0);
    // divisor 5, partial last word
    run_case(1, 13, 3, 32'h0000_2000, 32'd10, 32'h0000_0000, 32'hFFFF_FFFF, 0);
    // divisor 2
    run_case(1, 7, 6, 32'h8000_0000, 32'd8, 32'h1111_1111, 32'h0, 0);
    // divisor 15: timing untouched
    run_case(1, 8, 9, 32'hFFFF_FFF0, 32'd4, 32'hABCD_EF01, 32'h0000_0F00, 0);
    // divisor 16
    run_case(1, 0, 1, 32'h0000_0400, 32'd12, 32'h7777_7777, 32'hAAAA_AAAA, 0);
    // no calibration, zero length: checksum cleared by start
    run_case(0, 7, 5, 32'h0000_3000, 32'd0, 32'h1357_9BDF, 32'h2468_ACE0, 0);
    // writes and start while busy ignored
    run_case(1, 14, 7, 32'h0000_5000, 32'd40, 32'h0, 32'h0, 1);
    // calibrate path with zero length
    run_case(1, 6, 4, 32'h0000_6000, 32'd0, 32'hF0F0_F0F0, 32'h0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    bad++; total++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule